// File: doc/BRIEF.md
# Exception-Return Status Shifter

This block performs the status-word update that a processor core applies when it returns from an exception handler or from a non-maskable-interrupt handler. The 32-bit status word keeps a small stack of saved flag groups in its low 28 bits. A return pops that stack by shifting those bits right by ten places. The two top bits pass through untouched, and bits 29 and 28 are cleared.

After the pop, the block sets the pending flag when the pre-pop restart flag was clear. On an NMI return it also forces the NMI-mask flag. If the restored status selects user mode, it moves the live stack pointer into the kernel-stack-pointer register and loads the stack pointer from the user stack pointer.

The update takes its inputs in the cycle the return strobe is high. The results appear on registered outputs after the next rising clock edge and hold until the next strobe.

Top module: `status_pop_unit`

## Requirements
- R1: On a strobe, `newStatus[31:30]` equals `curStatus[31:30]`, `newStatus[29:18]` is zero, and every other bit of `newStatus[17:0]` equals `curStatus[27:10]`. The flag bits 7 (pending) and 9 (NMI mask) follow R2 to R5 instead.
- R2: For either return kind, if `curStatus[8]` (restart flag) is 0, then `newStatus[7]` (pending) is 1.
- R3: If `curStatus[8]` is 1, then `newStatus[7]` equals the shifted-down value `curStatus[17]`.
- R4: When `retKind` is 1 (NMI return), `newStatus[9]` (NMI mask) is 1 whatever the other bits were.
- R5: When `retKind` is 0 (exception return), `newStatus[9]` equals `curStatus[19]`.
- R6: If the shifted user-mode flag `newStatus[6]` (taken from `curStatus[16]`) is 1, then `newSp` takes `userSp` and `kernSp` takes `curSp`.
- R7: If the shifted user-mode flag is 0, then `newSp` takes `curSp` and `kernSp` keeps its previous value.
- R8: Outputs change only on the clock edge that samples `retValid` high. With `retValid` low, all outputs hold.
- R9: While `rstN` is low, `newStatus`, `newSp` and `kernSp` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retValid | input | 1 | Return strobe, one cycle per return |
| retKind | input | 1 | 0 = exception return, 1 = NMI return |
| curStatus | input | 32 | Status word before the return |
| curSp | input | 32 | Current stack pointer |
| userSp | input | 32 | Saved user stack pointer |
| newStatus | output | 32 | Status word after the return |
| newSp | output | 32 | Stack pointer after the return |
| kernSp | output | 32 | Saved kernel stack pointer |

## Verification
The in-RTL assertions check on every cycle the properties that hold for every strobe:
- the preserved top bits and the cleared middle field;
- the forced pending flag when the restart flag is clear;
- the forced NMI mask on NMI returns;
- both branches of the stack-pointer swap;
- the hold of all outputs when no strobe is present.

Only the bench scenarios can show the exact pass-through of shifted bits, including the case where a set restart flag lets the shifted-in pending bit through unchanged. The same applies to the exception return that leaves bit 9 as shifted, to the retained kernel pointer across several non-user returns, and to the reset values.

// File: rtl/status_pop_pkg.sv
package status_pop_pkg;
  localparam int WORD_W    = 32;
  localparam int POP_SHIFT = 10;
  localparam int KEEP_W    = 2;
  localparam int STACK_W   = 28;
  localparam int U_BIT     = 6;
  localparam int P_BIT     = 7;
  localparam int R_BIT     = 8;
  localparam int M_BIT     = 9;

  typedef struct packed {
    logic load;
    logic swapSp;
    logic forceP;
    logic forceM;
  } popCtrl_t;
endpackage

// File: rtl/status_pop_ctrl.sv
module status_pop_ctrl
  import status_pop_pkg::*;
(
  input  logic              retValid,
  input  logic              retKind,
  input  logic [WORD_W-1:0] curStatus,
  output popCtrl_t          ctrl
);
  localparam int U_SRC = U_BIT + POP_SHIFT;

  always_comb begin
    ctrl.load   = retValid;
    ctrl.swapSp = retValid && curStatus[U_SRC];
    ctrl.forceP = retValid && !curStatus[R_BIT];
    ctrl.forceM = retValid && retKind;
  end
endmodule

// File: rtl/status_pop_dp.sv
module status_pop_dp
  import status_pop_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  popCtrl_t          ctrl,
  input  logic              retValid,
  input  logic              retKind,
  input  logic [WORD_W-1:0] curStatus,
  input  logic [WORD_W-1:0] curSp,
  input  logic [WORD_W-1:0] userSp,
  output logic [WORD_W-1:0] newStatus,
  output logic [WORD_W-1:0] newSp,
  output logic [WORD_W-1:0] kernSp
);
  localparam int MID_W = WORD_W - KEEP_W - STACK_W;

  logic [STACK_W-1:0] poppedLow;
  logic [WORD_W-1:0]  shifted;
  logic [WORD_W-1:0]  nextStatus;

  always_comb begin
    poppedLow  = curStatus[STACK_W-1:0] >> POP_SHIFT;
    shifted    = {curStatus[WORD_W-1 -: KEEP_W], {MID_W{1'b0}}, poppedLow};
    nextStatus = shifted;
    if (ctrl.forceP) nextStatus[P_BIT] = 1'b1;
    if (ctrl.forceM) nextStatus[M_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newStatus <= '0;
      newSp     <= '0;
      kernSp    <= '0;
    end else if (ctrl.load) begin
      newStatus <= nextStatus;
      if (ctrl.swapSp) begin
        kernSp <= curSp;
        newSp  <= userSp;
      end else begin
        newSp  <= curSp;
      end
    end
  end

  // R1: top bits kept, middle field cleared
  a_r1_top_and_mid: assert property (@(posedge clk) disable iff (!rstN)
    retValid |=> (newStatus[31:30] == $past(curStatus[31:30])) && (newStatus[29:18] == '0));
  // R2: pending set when restart flag was clear
  a_r2_pending_set: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && !curStatus[R_BIT]) |=> newStatus[P_BIT]);
  // R4: NMI return always sets mask
  a_r4_nmi_mask: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && retKind) |=> newStatus[M_BIT]);
  // R6: user-mode swap
  a_r6_user_swap: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && curStatus[U_BIT + POP_SHIFT]) |=>
      (newSp == $past(userSp)) && (kernSp == $past(curSp)) && newStatus[U_BIT]);
  // R7: no swap keeps kernel pointer
  a_r7_no_swap: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && !curStatus[U_BIT + POP_SHIFT]) |=>
      $stable(kernSp) && (newSp == $past(curSp)) && !newStatus[U_BIT]);
  // R8: hold without strobe
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !retValid |=> $stable(newStatus) && $stable(newSp) && $stable(kernSp));
endmodule

// File: rtl/status_pop_unit.sv
module status_pop_unit
  import status_pop_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              retValid,
  input  logic              retKind,
  input  logic [WORD_W-1:0] curStatus,
  input  logic [WORD_W-1:0] curSp,
  input  logic [WORD_W-1:0] userSp,
  output logic [WORD_W-1:0] newStatus,
  output logic [WORD_W-1:0] newSp,
  output logic [WORD_W-1:0] kernSp
);
  popCtrl_t ctrl;

  status_pop_ctrl u_ctrl (
    .retValid (retValid),
    .retKind  (retKind),
    .curStatus(curStatus),
    .ctrl     (ctrl)
  );

  status_pop_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .retValid (retValid),
    .retKind  (retKind),
    .curStatus(curStatus),
    .curSp    (curSp),
    .userSp   (userSp),
    .newStatus(newStatus),
    .newSp    (newSp),
    .kernSp   (kernSp)
  );
endmodule

// File: tb/status_pop_unit_tb.sv
module status_pop_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        retValid = 1'b0;
  logic        retKind = 1'b0;
  logic [31:0] curStatus = '0;
  logic [31:0] curSp = '0;
  logic [31:0] userSp = '0;
  logic [31:0] newStatus, newSp, kernSp;

  int checks = 0;
  int failures = 0;
  logic [31:0] modelKsp = '0;
  logic [31:0] modelSp = '0;
  logic [31:0] modelSt = '0;

  always #4 clk = ~clk;

  status_pop_unit u_dut (
    .clk(clk), .rstN(rstN), .retValid(retValid), .retKind(retKind),
    .curStatus(curStatus), .curSp(curSp), .userSp(userSp),
    .newStatus(newStatus), .newSp(newSp), .kernSp(kernSp)
  );

  // stimulus: {kind, status}
  localparam logic [32:0] VEC [10] = '{
    {1'b0, 32'hC000_0000}, {1'b1, 32'h0000_0000}, {1'b0, 32'hFFFF_FFFF},
    {1'b1, 32'hFFFF_FFFF}, {1'b0, 32'h0001_0100}, {1'b1, 32'h0002_0100},
    {1'b0, 32'h0008_0100}, {1'b0, 32'h4FFF_FEFF}, {1'b1, 32'h8000_0100},
    {1'b0, 32'h3555_AAAA}
  };

  function automatic logic [31:0] expStatus(input logic [31:0] s, input logic k);
    logic [31:0] e;
    e = {s[31:30], 12'b0, s[27:10]};
    if (!s[8]) e[7] = 1'b1;
    if (k) e[9] = 1'b1;
    return e;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doRet(input logic [31:0] s, input logic k,
                       input logic [31:0] sp, input logic [31:0] usp);
    @(negedge clk);
    retValid = 1'b1; retKind = k; curStatus = s; curSp = sp; userSp = usp;
    modelSt = expStatus(s, k);
    if (s[16]) begin modelKsp = sp; modelSp = usp; end
    else modelSp = sp;
    @(negedge clk);
    retValid = 1'b0; curStatus = ~s; curSp = 32'hDEAD_0000; userSp = 32'hBEEF_0000;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 status", newStatus, 32'h0);
    check("R9 sp", newSp, 32'h0);
    check("R9 ksp", kernSp, 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < 10; i++) begin
      doRet(VEC[i][31:0], VEC[i][32], 32'h1000 + i, 32'h2000 + i);
      check("R1..R5 status vec", newStatus, modelSt);
      check("R6/R7 sp vec", newSp, modelSp);
      check("R6/R7 ksp vec", kernSp, modelKsp);
    end

    // directed hand-computed cases
    doRet(32'hC000_0000, 1'b0, 32'h11, 32'h22);
    check("R1 R2 top kept pending forced", newStatus, 32'hC000_0080);
    doRet(32'hFFFF_FFFF, 1'b1, 32'h33, 32'h44);
    check("R1 R3 R4 all ones", newStatus, 32'hC003_FFFF);
    check("R6 sp from user", newSp, 32'h44);
    check("R6 ksp saved", kernSp, 32'h33);
    doRet(32'h0001_0100, 1'b0, 32'h55, 32'h66);
    check("R3 R5 restart set no pending", newStatus, 32'h0000_0040);
    check("R6 second swap ksp", kernSp, 32'h55);
    doRet(32'h0000_0000, 1'b1, 32'h77, 32'h88);
    check("R2 R4 nmi zero", newStatus, 32'h0000_0280);
    check("R7 sp unchanged", newSp, 32'h77);
    check("R7 ksp retained", kernSp, 32'h55);
    doRet(32'h0008_0100, 1'b0, 32'h99, 32'hAA);
    check("R5 mask passes through", newStatus, 32'h0000_0200);
    doRet(32'h0002_0100, 1'b0, 32'hBB, 32'hCC);
    check("R3 shifted pending passes", newStatus, 32'h0000_0080);

    // R8: hold with no strobe and changing inputs
    repeat (4) @(negedge clk);
    check("R8 hold status", newStatus, 32'h0000_0080);
    check("R8 hold sp", newSp, 32'hBB);
    check("R8 hold ksp", kernSp, 32'h55);

    // R9: reset again clears outputs
    rstN = 1'b0;
    @(negedge clk);
    check("R9 re-reset status", newStatus, 32'h0);
    check("R9 re-reset ksp", kernSp, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule